// File: doc/BRIEF.md
# Virtual-to-Physical DMA Channel Allocator

This block lends a small pool of physical transfer engines to a larger population of virtual channels. A virtual channel that has issued work asks to be queued; the block keeps waiting channels in strict arrival order. Whenever an engine is idle, it binds that engine to the oldest waiting channel and pulses a start strobe carrying both indices, so the engine can begin fetching descriptors for its new owner.

When an engine reports completion, the block consults the owner's "more work ready" flag. If set, the engine stays with its owner. If clear, the binding is dissolved and the engine returns to the pool. A virtual channel may also be paused, resumed or terminated through a single command port. Commands act on the bound engine when one exists, and on the pending queue otherwise. Status outputs show which engines are busy or paused and which engine, if any, each virtual channel holds.

Default sizing is 16 engines, 53 virtual channels and peripheral request ports 0 to 30. The transfer datapath and descriptor handling live elsewhere.

Top module: `dma_chan_binder`

## Requirements
- R1: While reset is low and in the first cycle after it, every engine reads free and unpaused, no virtual channel reads bound, and start_valid and stop_valid are low.
- R2: A command is valid only when cmd_valid is high and cmd_vch < NUM_VCH. An issue command (cmd_op = 0) appends cmd_vch to the tail of the pending queue only if three conditions hold: cmd_port <= MAX_PORT, the channel holds no engine, and the channel is not already queued. Otherwise the issue command changes nothing.
- R3: Each cycle at most one binding is made. It takes the lowest-indexed free engine and the head of the queue, and removes that head. On the next clock edge the engine reads busy, and start_valid pulses for one cycle with start_pch and start_vch naming the pair.
- R4: A pch_done bit on a busy engine keeps the binding when vch_more[owner] is 1. When vch_more[owner] is 0, the engine reads free and unpaused after the next edge.
- R5: A pause command (cmd_op = 1) on a bound channel marks its engine paused. On an unbound channel it removes the channel from the queue.
- R6: A resume command (cmd_op = 2) on a bound channel clears its engine's pause mark. On an unbound channel it queues the channel at the tail only if vch_more for it is 1 and it is not already queued.
- R7: A terminate command (cmd_op = 3) removes the channel from the queue. If the channel is bound, the engine reads free and unpaused after the next edge, and stop_valid pulses for one cycle with stop_pch naming the engine.
- R8: No binding is made in a cycle that carries a valid pause or terminate command.
- R9: vch_bound_valid[v] is 1 exactly when some busy engine is owned by v. vch_bound_pch[v*PCH_W +: PCH_W] then gives that engine's index.
- R10: A pch_done bit on a free engine has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 issue, 1 pause, 2 resume, 3 terminate |
| cmd_vch | input | VCH_W | Virtual channel addressed by the command |
| cmd_port | input | PORT_W | Peripheral request port supplied with an issue |
| vch_more | input | NUM_VCH | Per virtual channel: another descriptor is ready |
| pch_done | input | NUM_PCH | Per engine: current descriptor finished |
| start_valid | output | 1 | New binding made |
| start_pch | output | PCH_W | Engine of the new binding |
| start_vch | output | VCH_W | Owner of the new binding |
| stop_valid | output | 1 | Engine halted by terminate |
| stop_pch | output | PCH_W | Engine halted |
| pch_busy | output | NUM_PCH | Engine is bound |
| pch_paused | output | NUM_PCH | Engine is paused |
| vch_bound_valid | output | NUM_VCH | Virtual channel holds an engine |
| vch_bound_pch | output | NUM_VCH*PCH_W | Engine held by each virtual channel |

## Verification
A corrupted queue shows up as a start pulse that names the wrong owner, or that comes out of arrival order, at the first binding after the corruption. A queue entry that was never removed shows up as a channel bound twice, which the bound-status vector exposes in the same cycle as the start pulse. A wrong owner or busy bit appears on pch_busy and vch_bound_* one edge after the command or completion that caused it. The bench compares every output on every cycle against an arithmetic model, so any of these errors surfaces within one cycle of reaching the ports.

// File: rtl/dma_chan_binder_pkg.sv
`timescale 1ns/1ps
// Shared types of the channel allocator: the command opcode encoding.
package dma_chan_binder_pkg;
    typedef enum logic [1:0] {
        OP_ISSUE  = 2'd0,
        OP_PAUSE  = 2'd1,
        OP_RESUME = 2'd2,
        OP_KILL   = 2'd3
    } binder_op_e;
endpackage

// File: rtl/dma_chan_binder_queue.sv
`timescale 1ns/1ps
// Ordered pending queue of virtual channel indices with per-id membership.
// A head pop or removal of one matching entry compacts the entries behind it.
// Assumes: each id is present at most once (caller checks membership before
// push), push and removal by id never occur together, and pop only when
// head_valid is high.
module dma_chan_binder_queue #(
    parameter int DEPTH = 53,
    parameter int IDW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDW-1:0]   push_id,
    input  logic             rm,
    input  logic [IDW-1:0]   rm_id,
    input  logic             pop,
    output logic             head_valid,
    output logic [IDW-1:0]   head_id,
    output logic [DEPTH-1:0] member
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [IDW-1:0]   slot_q [DEPTH];
    logic [IDW-1:0]   slot_n [DEPTH];
    logic [IDW-1:0]   ext    [DEPTH+1];
    logic [CW-1:0]    cnt_q, cnt_n, cnt_cut;
    logic [DEPTH-1:0] mem_q, mem_n, hit, shift;
    logic             gone;

    // Locate the entry to drop, compact behind it, then append at the tail.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = (CW'(i) < cnt_q) && (slot_q[i] == rm_id);
            ext[i] = slot_q[i];
        end
        ext[DEPTH] = '0;
        shift = '0;
        if (pop) begin
            shift = '1;
        end else if (rm) begin
            shift[0] = hit[0];
            for (int i = 1; i < DEPTH; i++) begin
                shift[i] = shift[i-1] | hit[i];
            end
        end
        gone = pop ? (cnt_q != '0) : (rm && (|hit));
        for (int i = 0; i < DEPTH; i++) begin
            slot_n[i] = shift[i] ? ext[i+1] : slot_q[i];
        end
        cnt_cut = cnt_q - CW'(gone);
        cnt_n   = cnt_cut;
        mem_n   = mem_q;
        if (pop) mem_n[slot_q[0]] = 1'b0;
        if (rm)  mem_n[rm_id]     = 1'b0;
        if (push) begin
            slot_n[cnt_cut] = push_id;
            cnt_n           = cnt_cut + CW'(1);
            mem_n[push_id]  = 1'b1;
        end
    end

    // Hold queue contents, occupancy and membership flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mem_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            mem_q <= mem_n;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
        end
    end

    assign head_valid = (cnt_q != '0);
    assign head_id    = slot_q[0];
    assign member     = mem_q;
endmodule

// File: rtl/dma_chan_binder_pick.sv
`timescale 1ns/1ps
// Lowest-index finder over a free-engine mask.
// Assumes nothing about the mask; found is low when no bit is set.
module dma_chan_binder_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] free,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan_binder_status.sv
`timescale 1ns/1ps
// Reverse lookup from the engine ownership table to a per-virtual-channel
// bound flag and engine index.
// Assumes at most one busy engine is owned by any virtual channel.
module dma_chan_binder_status #(
    parameter int NP = 16,
    parameter int NV = 53,
    parameter int PW = 4,
    parameter int VW = 6
) (
    input  logic [NP-1:0]    busy,
    input  logic [NP*VW-1:0] owner,
    output logic [NV-1:0]    bound_valid,
    output logic [NV*PW-1:0] bound_pch
);
    for (genvar v = 0; v < NV; v++) begin : g_vch
        logic          bv;
        logic [PW-1:0] bp;
        // Find the busy engine whose owner equals this virtual channel.
        always_comb begin
            bv = 1'b0;
            bp = '0;
            for (int p = 0; p < NP; p++) begin
                if (busy[p] && (owner[p*VW +: VW] == VW'(v))) begin
                    bv = 1'b1;
                    bp = PW'(p);
                end
            end
        end
        assign bound_valid[v]         = bv;
        assign bound_pch[v*PW +: PW]  = bp;
    end
endmodule

// File: rtl/dma_chan_binder.sv
`timescale 1ns/1ps
// Virtual-to-physical DMA channel allocator.
// Queues virtual channels in arrival order, binds one free engine per cycle
// to the head of the queue, keeps or releases engines on completion, and
// applies pause, resume and terminate commands to the engine or the queue.
// Assumes: one command per cycle; vch_more reflects the owner's descriptor
// list in the same cycle as pch_done.
module dma_chan_binder
    import dma_chan_binder_pkg::*;
#(
    parameter int NUM_PCH  = 16,
    parameter int NUM_VCH  = 53,
    parameter int MAX_PORT = 30,
    parameter int PORT_W   = 5,
    parameter int PCH_W    = $clog2(NUM_PCH),
    parameter int VCH_W    = $clog2(NUM_VCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [VCH_W-1:0]         cmd_vch,
    input  logic [PORT_W-1:0]        cmd_port,
    input  logic [NUM_VCH-1:0]       vch_more,
    input  logic [NUM_PCH-1:0]       pch_done,
    output logic                     start_valid,
    output logic [PCH_W-1:0]         start_pch,
    output logic [VCH_W-1:0]         start_vch,
    output logic                     stop_valid,
    output logic [PCH_W-1:0]         stop_pch,
    output logic [NUM_PCH-1:0]       pch_busy,
    output logic [NUM_PCH-1:0]       pch_paused,
    output logic [NUM_VCH-1:0]       vch_bound_valid,
    output logic [NUM_VCH*PCH_W-1:0] vch_bound_pch
);
    localparam logic [VCH_W:0]  NV_LIM   = (VCH_W+1)'(NUM_VCH);
    localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(MAX_PORT);

    logic [NUM_PCH-1:0]       busy_q, busy_n, paused_q, paused_n;
    logic [NUM_PCH*VCH_W-1:0] owner_q, owner_n;
    logic                     vch_ok, cmd_act, port_ok;
    logic [VCH_W-1:0]         vsel;
    binder_op_e               op;
    logic                     cmd_bound, inq_sel;
    logic [PCH_W-1:0]         cmd_pch;
    logic                     q_push, q_rm, stall, alloc;
    logic                     head_valid;
    logic [VCH_W-1:0]         head_id;
    logic [NUM_VCH-1:0]       member;
    logic                     free_found;
    logic [PCH_W-1:0]         free_idx;
    logic [NUM_VCH-1:0]       bound_valid;
    logic [NUM_VCH*PCH_W-1:0] bound_pch;

    dma_chan_binder_queue #(.DEPTH(NUM_VCH), .IDW(VCH_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_id    (vsel),
        .rm         (q_rm),
        .rm_id      (vsel),
        .pop        (alloc),
        .head_valid (head_valid),
        .head_id    (head_id),
        .member     (member)
    );

    dma_chan_binder_pick #(.N(NUM_PCH), .W(PCH_W)) u_pick (
        .free  (~busy_q),
        .found (free_found),
        .idx   (free_idx)
    );

    dma_chan_binder_status #(.NP(NUM_PCH), .NV(NUM_VCH), .PW(PCH_W), .VW(VCH_W)) u_status (
        .busy        (busy_q),
        .owner       (owner_q),
        .bound_valid (bound_valid),
        .bound_pch   (bound_pch)
    );

    // Decode the command and look up the addressed channel's binding.
    always_comb begin
        vch_ok    = ({1'b0, cmd_vch} < NV_LIM);
        vsel      = vch_ok ? cmd_vch : '0;
        cmd_act   = cmd_valid && vch_ok;
        op        = binder_op_e'(cmd_op);
        port_ok   = ({1'b0, cmd_port} <= PORT_LIM);
        cmd_bound = bound_valid[vsel];
        cmd_pch   = bound_pch[vsel*PCH_W +: PCH_W];
        inq_sel   = member[vsel];
        q_push    = cmd_act && !cmd_bound && !inq_sel &&
                    (((op == OP_ISSUE) && port_ok) ||
                     ((op == OP_RESUME) && vch_more[vsel]));
        q_rm      = cmd_act && (((op == OP_PAUSE) && !cmd_bound) || (op == OP_KILL));
        stall     = cmd_act && ((op == OP_PAUSE) || (op == OP_KILL));
        alloc     = !stall && head_valid && free_found;
    end

    // Next engine state: commands, then completions, then the new binding.
    always_comb begin
        busy_n   = busy_q;
        paused_n = paused_q;
        owner_n  = owner_q;
        if (cmd_act && cmd_bound) begin
            case (op)
                OP_PAUSE:  paused_n[cmd_pch] = 1'b1;
                OP_RESUME: paused_n[cmd_pch] = 1'b0;
                OP_KILL: begin
                    busy_n[cmd_pch]   = 1'b0;
                    paused_n[cmd_pch] = 1'b0;
                end
                default: ;
            endcase
        end
        for (int p = 0; p < NUM_PCH; p++) begin
            if (busy_q[p] && pch_done[p] && !vch_more[owner_q[p*VCH_W +: VCH_W]]) begin
                busy_n[p]   = 1'b0;
                paused_n[p] = 1'b0;
            end
        end
        if (alloc) begin
            busy_n[free_idx]                     = 1'b1;
            paused_n[free_idx]                   = 1'b0;
            owner_n[free_idx*VCH_W +: VCH_W]     = head_id;
        end
    end

    // Register engine state and the one-cycle start/stop strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= '0;
            paused_q    <= '0;
            owner_q     <= '0;
            start_valid <= 1'b0;
            start_pch   <= '0;
            start_vch   <= '0;
            stop_valid  <= 1'b0;
            stop_pch    <= '0;
        end else begin
            busy_q      <= busy_n;
            paused_q    <= paused_n;
            owner_q     <= owner_n;
            start_valid <= alloc;
            if (alloc) begin
                start_pch <= free_idx;
                start_vch <= head_id;
            end
            stop_valid  <= cmd_act && (op == OP_KILL) && cmd_bound;
            if (cmd_act && (op == OP_KILL) && cmd_bound) stop_pch <= cmd_pch;
        end
    end

    assign pch_busy        = busy_q;
    assign pch_paused      = paused_q;
    assign vch_bound_valid = bound_valid;
    assign vch_bound_pch   = bound_pch;
endmodule

// File: rtl/dma_chan_binder_chk.sv
`timescale 1ns/1ps
// Property checker for the channel allocator, bound into every instance.
// Assumes the port names of dma_chan_binder.
module dma_chan_binder_chk #(
    parameter int NUM_PCH  = 16,
    parameter int NUM_VCH  = 53,
    parameter int MAX_PORT = 30,
    parameter int PORT_W   = 5,
    parameter int PCH_W    = $clog2(NUM_PCH),
    parameter int VCH_W    = $clog2(NUM_VCH)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [1:0]               cmd_op,
    input logic [VCH_W-1:0]         cmd_vch,
    input logic                     start_valid,
    input logic [PCH_W-1:0]         start_pch,
    input logic [VCH_W-1:0]         start_vch,
    input logic                     stop_valid,
    input logic [PCH_W-1:0]         stop_pch,
    input logic [NUM_PCH-1:0]       pch_busy,
    input logic [NUM_PCH-1:0]       pch_paused,
    input logic [NUM_VCH-1:0]       vch_bound_valid,
    input logic [NUM_VCH*PCH_W-1:0] vch_bound_pch
);
    logic [NUM_PCH-1:0] busy_prev;
    logic               halt_prev;

    // Remember last cycle's busy mask and whether a pause/terminate was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_prev <= '0;
            halt_prev <= 1'b0;
        end else begin
            busy_prev <= pch_busy;
            halt_prev <= cmd_valid && (cmd_op[0] == 1'b1) &&
                         ({1'b0, cmd_vch} < (VCH_W+1)'(NUM_VCH));
        end
    end

    // R3
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> (!busy_prev[start_pch] && pch_busy[start_pch]));

    // R8
    no_bind_on_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> !halt_prev);

    // R9
    start_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> (vch_bound_valid[start_vch] &&
                         (vch_bound_pch[start_vch*PCH_W +: PCH_W] == start_pch)));

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_valid |-> (!pch_busy[stop_pch] && !pch_paused[stop_pch]));

    // R5
    pause_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pch_paused & ~pch_busy) == '0));

    // R9
    bound_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(vch_bound_valid) == $countones(pch_busy)));
endmodule

bind dma_chan_binder dma_chan_binder_chk #(
    .NUM_PCH(NUM_PCH), .NUM_VCH(NUM_VCH), .MAX_PORT(MAX_PORT),
    .PORT_W(PORT_W), .PCH_W(PCH_W), .VCH_W(VCH_W)
) u_chk (.*);

// File: tb/dma_chan_binder_bench.sv
`timescale 1ns/1ps
// Self-checking bench: small configuration, every output compared each
// cycle against an arithmetic model of the requirements.
module dma_chan_binder_bench;
    localparam int NP = 4, NV = 7, PW = 2, VW = 3, PRW = 5, MAXP = 30;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n, cmd_valid;
    logic [1:0]      cmd_op;
    logic [VW-1:0]   cmd_vch;
    logic [PRW-1:0]  cmd_port;
    logic [NV-1:0]   vch_more;
    logic [NP-1:0]   pch_done;
    logic            start_valid, stop_valid;
    logic [PW-1:0]   start_pch, stop_pch;
    logic [VW-1:0]   start_vch;
    logic [NP-1:0]   pch_busy, pch_paused;
    logic [NV-1:0]   vch_bound_valid;
    logic [NV*PW-1:0] vch_bound_pch;

    dma_chan_binder #(.NUM_PCH(NP), .NUM_VCH(NV), .MAX_PORT(MAXP), .PORT_W(PRW)) u_dma_chan_binder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vch(cmd_vch), .cmd_port(cmd_port), .vch_more(vch_more),
        .pch_done(pch_done), .start_valid(start_valid), .start_pch(start_pch),
        .start_vch(start_vch), .stop_valid(stop_valid), .stop_pch(stop_pch),
        .pch_busy(pch_busy), .pch_paused(pch_paused),
        .vch_bound_valid(vch_bound_valid), .vch_bound_pch(vch_bound_pch)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Model state
    int m_busy [NP];
    int m_own  [NP];
    int m_pause[NP];
    int m_q[$];

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(int es, int esp, int esv, int et, int etp);
        check("R3", "start_valid", int'(start_valid), es);
        if (es != 0) begin
            check("R3", "start_pch", int'(start_pch), esp);
            check("R3", "start_vch", int'(start_vch), esv);
        end
        check("R7", "stop_valid", int'(stop_valid), et);
        if (et != 0) check("R7", "stop_pch", int'(stop_pch), etp);
        for (int p = 0; p < NP; p++) begin
            check("R4", $sformatf("pch_busy[%0d]", p), int'(pch_busy[p]), m_busy[p]);
            check("R5", $sformatf("pch_paused[%0d]", p), int'(pch_paused[p]), m_pause[p]);
        end
        for (int v = 0; v < NV; v++) begin
            int bp = -1;
            for (int p = 0; p < NP; p++) if (m_busy[p] != 0 && m_own[p] == v) bp = p;
            check("R9", $sformatf("vch_bound_valid[%0d]", v), int'(vch_bound_valid[v]), (bp >= 0) ? 1 : 0);
            if (bp >= 0)
                check("R9", $sformatf("vch_bound_pch[%0d]", v), int'(vch_bound_pch[v*PW +: PW]), bp);
        end
    endtask

    // One clock of stimulus; the model derives every expected output.
    task automatic step(bit cv, int op, int v, int port, logic [NP-1:0] done, logic [NV-1:0] more);
        int bnd, freep, es, esp, esv, et, etp;
        bit vok, inq, stall, alloc, push;
        int nb[NP], np_[NP], no[NP];
        cmd_valid = cv; cmd_op = 2'(op); cmd_vch = VW'(v); cmd_port = PRW'(port);
        pch_done = done; vch_more = more;
        vok = (v < NV);
        bnd = -1; inq = 0;
        if (vok) begin
            for (int p = 0; p < NP; p++) if (m_busy[p] != 0 && m_own[p] == v) bnd = p;
            foreach (m_q[i]) if (m_q[i] == v) inq = 1;
        end
        stall = cv && vok && (op == 1 || op == 3);           // R8
        freep = -1;
        for (int p = NP - 1; p >= 0; p--) if (m_busy[p] == 0) freep = p;
        alloc = !stall && (m_q.size() > 0) && (freep >= 0);
        for (int p = 0; p < NP; p++) begin nb[p] = m_busy[p]; np_[p] = m_pause[p]; no[p] = m_own[p]; end
        es = 0; esp = 0; esv = 0; et = 0; etp = 0; push = 0;
        if (cv && vok) begin
            case (op)
                0: push = (port <= MAXP) && (bnd < 0) && !inq;         // R2
                1: begin                                                // R5
                    if (bnd >= 0) np_[bnd] = 1;
                    else foreach (m_q[i]) if (m_q[i] == v) begin m_q.delete(i); break; end
                end
                2: begin                                                // R6
                    if (bnd >= 0) np_[bnd] = 0;
                    else push = more[v] && !inq;
                end
                default: begin                                          // R7
                    foreach (m_q[i]) if (m_q[i] == v) begin m_q.delete(i); break; end
                    if (bnd >= 0) begin nb[bnd] = 0; np_[bnd] = 0; et = 1; etp = bnd; end
                end
            endcase
        end
        for (int p = 0; p < NP; p++)                                    // R4, R10
            if (m_busy[p] != 0 && done[p] && !more[m_own[p]]) begin nb[p] = 0; np_[p] = 0; end
        if (alloc) begin                                                // R3
            esv = m_q.pop_front();
            esp = freep; es = 1;
            nb[freep] = 1; np_[freep] = 0; no[freep] = esv;
        end
        if (push) m_q.push_back(v);
        @(posedge clk); #1;
        for (int p = 0; p < NP; p++) begin m_busy[p] = nb[p]; m_pause[p] = np_[p]; m_own[p] = no[p]; end
        compare_all(es, esp, esv, et, etp);
    endtask

    task automatic idle(int n, logic [NV-1:0] more);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, more);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_vch = 0; cmd_port = 0;
        vch_more = '0; pch_done = '0;
        for (int p = 0; p < NP; p++) begin m_busy[p] = 0; m_own[p] = 0; m_pause[p] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: state held in reset
        compare_all(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, '0, '0);   // R1: first cycle after reset

        // R2, R3: six requesters for four engines, bound lowest engine first
        for (int v = 0; v < 6; v++) step(1, 0, v, v + 1, '0, '0);
        idle(2, '0);
        // R2: port 31 rejected, port 30 accepted, duplicate and bound issues ignored
        step(1, 0, 6, 31, '0, '0);
        step(1, 0, 6, 30, '0, '0);
        step(1, 0, 6, 30, '0, '0);
        step(1, 0, 0, 3, '0, '0);
        step(1, 0, 7, 3, '0, '0);   // out-of-range channel index
        // R4: completion with more work keeps, without releases
        step(0, 0, 0, 0, 4'b0001, 7'b0000001);
        step(0, 0, 0, 0, 4'b0010, 7'b0000000);
        idle(2, '0);
        // R5, R6: pause/resume bound engine; pause queued, resume with and without work
        step(1, 1, 2, 0, '0, '0);
        step(1, 2, 2, 0, '0, '0);
        step(1, 1, 2, 0, '0, '0);
        step(1, 1, 6, 0, '0, '0);
        step(1, 2, 6, 0, '0, 7'b0000000);
        step(1, 2, 6, 0, '0, 7'b1000000);
        step(1, 2, 6, 0, '0, 7'b1000000);
        // R7: terminate a paused bound channel and a queued one
        step(1, 3, 2, 0, '0, '0);
        step(1, 3, 6, 0, '0, '0);
        // R8: halt commands while an engine is free and the queue holds work
        step(1, 0, 6, 1, '0, '0);
        step(1, 1, 5, 0, '0, '0);
        step(1, 3, 5, 0, '0, '0);
        idle(2, '0);
        // R10: completion on free engines
        step(0, 0, 0, 0, 4'b1111, '0);
        step(0, 0, 0, 0, 4'b1111, '0);
        idle(2, '0);

        // Near-exhaustive sweep of command, channel, port, completion, more-work
        for (int i = 0; i < 6000; i++) begin
            int op, v, port;
            bit cv;
            logic [NP-1:0] dn;
            logic [NV-1:0] mr;
            cv   = ($urandom_range(0, 3) != 0);
            op   = (i % 3 == 0) ? 0 : $urandom_range(0, 3);
            v    = $urandom_range(0, NV);
            port = (i % 17 == 0) ? 31 : $urandom_range(0, MAXP);
            for (int p = 0; p < NP; p++) dn[p] = ($urandom_range(0, 4) == 0);
            mr   = NV'($urandom);
            step(cv, op, v, port, dn, mr);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule